// File: doc/BRIEF.md
# Four-Level 16 KB-Granule Translation Table Walker

The walker resolves one 48-bit virtual address against a four-level translation table built with a 16 KB granule. It takes a request with the virtual address, the byte address of the first table and a stage select. The stage select chooses between the first-stage and second-stage write-permission rules. It then fetches one 64-bit descriptor per level over a simple memory port. A read is a request, held until granted, followed by a single response beat.

After each descriptor arrives the walker decodes it. An invalid descriptor ends the walk with a fault and reports the level. A table descriptor sends the walk one level deeper. A leaf ends the walk with the output physical address, a mask of the mapped region and a write-permission flag. Only one walk is in progress at a time. The result is shown for exactly one cycle on `done`.

Top module: `pt16_walker`

## Requirements
- R1: While reset is held and just after it, `req_ready` is 1, `done` is 0 and `mem_req_valid` is 0.
- R2: The descriptor for level L is read from byte address `table + 8*index`. Level 0 takes its index from VA bit 47 alone. Level 1 uses VA[46:36], level 2 uses VA[35:25] and level 3 uses VA[24:14]. The level-0 table is `req_base`.
- R3: A descriptor at levels 0 to 2 is valid when bit 0 is 1. At level 3, bits 0 and 1 must both be 1. An invalid descriptor ends the walk with `fault`=1, `end_level` set to that level, and `out_pa`, `page_mask` and `writable` all 0. No further read is issued.
- R4: At levels 0 and 1 a valid descriptor always points to a next table. At level 2 it is a leaf when bit 1 is 0, and a table otherwise. At level 3 it is always a leaf. On a leaf, `end_level` reports the level (2 or 3).
- R5: For a table descriptor, the next table's base is descriptor bits 47:12 with the low 12 bits zero. Descriptor bits outside 47:12 do not change the next read address.
- R6: For a leaf, `out_pa` takes descriptor bits 47:25 at level 2, or bits 47:14 at level 3. The remaining low bits come from the VA.
- R7: `page_mask` has ones at bit n and above and zeros below. n is 25 for a level-2 leaf and 14 for a level-3 leaf. When descriptor bit 52 is 1, n widens to 30 and 21 respectively.
- R8: When `req_stage2` is 1, `writable` is 1 exactly when descriptor bits 7 and 6 are both 1. Otherwise `writable` is 1 exactly when bit 7 is 0.
- R9: A request is taken only while `req_ready` is 1, which is only when no walk is in progress. A `req_valid` seen while busy is ignored. `done` is high for exactly one cycle per walk, and `req_ready` is 1 again in the cycle after `done`.
- R10: `mem_req_valid` stays high with a stable `mem_addr` until `mem_req_ready`. Only one read is outstanding. The number of reads equals the number of levels visited.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Walk request strobe |
| req_ready | output | 1 | Walker idle, request taken this cycle |
| req_va | input | 48 | Virtual address to translate |
| req_base | input | 48 | Byte address of the level-0 table |
| req_stage2 | input | 1 | 1 selects the second-stage write rule |
| mem_req_valid | output | 1 | Descriptor read request |
| mem_req_ready | input | 1 | Memory accepts the read |
| mem_addr | output | 48 | Descriptor byte address |
| mem_rsp_valid | input | 1 | Descriptor data valid |
| mem_rsp_data | input | 64 | Descriptor returned by memory |
| done | output | 1 | One-cycle result strobe |
| fault | output | 1 | Walk ended on an invalid descriptor |
| end_level | output | 2 | Level at which the walk ended |
| out_pa | output | 48 | Translated physical address |
| page_mask | output | 48 | Ones above the mapped region's offset bits |
| writable | output | 1 | Write permission of the leaf |

## Verification
A wrong level counter or a wrong table register shows up at the next read. The `mem_addr` issued no longer matches the address the model derives from its own memory image. This is visible at the first read after the fault, normally within three cycles. A decode error on validity, leaf or contiguous bits either changes how many reads a walk makes or corrupts the registers presented on the `done` cycle. Both are compared on the cycle they occur. A sequencing error that takes a request while busy, or holds `done` for two cycles, is caught on every clock by tracking `req_ready` and `done` against the expected walk.

// File: rtl/pt16_pkg.sv
package pt16_pkg;
  localparam int VA_W    = 48;
  localparam int DESC_W  = 64;
  localparam int LVL_W   = 2;
  localparam int IDX_W   = 11;
  localparam int ENT_SH  = 3;
  localparam int TBL_SH  = 12;
  localparam int BLK_SH  = 25;
  localparam int PG_SH   = 14;
  localparam int BLK_CSH = 30;
  localparam int PG_CSH  = 21;
  localparam int CONT_B  = 52;
  localparam logic [LVL_W-1:0] LAST_LVL = 2'd3;

  typedef enum logic [2:0] {
    ST_IDLE, ST_ISSUE, ST_WAIT, ST_DECODE, ST_DONE
  } walk_st_e;

  function automatic logic [IDX_W-1:0] lvl_index(input logic [VA_W-1:0] va,
                                                 input logic [LVL_W-1:0] lvl);
    case (lvl)
      2'd0:    return {{(IDX_W-1){1'b0}}, va[47]};
      2'd1:    return va[46:36];
      2'd2:    return va[35:25];
      default: return va[24:14];
    endcase
  endfunction

  function automatic logic desc_ok(input logic [DESC_W-1:0] d,
                                   input logic [LVL_W-1:0] lvl);
    return (lvl == LAST_LVL) ? (d[0] & d[1]) : d[0];
  endfunction

  function automatic logic desc_is_leaf(input logic [DESC_W-1:0] d,
                                        input logic [LVL_W-1:0] lvl);
    case (lvl)
      2'd2:    return ~d[1];
      2'd3:    return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  function automatic int out_shift(input logic [LVL_W-1:0] lvl);
    return (lvl == LAST_LVL) ? PG_SH : BLK_SH;
  endfunction

  function automatic int mask_shift(input logic [DESC_W-1:0] d,
                                    input logic [LVL_W-1:0] lvl);
    if (d[CONT_B]) return (lvl == LAST_LVL) ? PG_CSH : BLK_CSH;
    return out_shift(lvl);
  endfunction

  function automatic logic may_write(input logic [DESC_W-1:0] d,
                                     input logic stage2);
    return stage2 ? (d[7] & d[6]) : ~d[7];
  endfunction
endpackage

// File: rtl/pt16_addr.sv
module pt16_addr import pt16_pkg::*; (
  input  logic [VA_W-1:0]  table_base,
  input  logic [VA_W-1:0]  va,
  input  logic [LVL_W-1:0] lvl,
  output logic [VA_W-1:0]  rd_addr
);
  localparam int PAD_W = VA_W - IDX_W - ENT_SH;

  logic [IDX_W-1:0] idx;

  always_comb begin
    idx     = lvl_index(va, lvl);
    rd_addr = table_base + {{PAD_W{1'b0}}, idx, {ENT_SH{1'b0}}};
  end
endmodule

// File: rtl/pt16_decode.sv
module pt16_decode import pt16_pkg::*; (
  input  logic [DESC_W-1:0] desc,
  input  logic [LVL_W-1:0]  lvl,
  input  logic [VA_W-1:0]   va,
  input  logic              stage2,
  output logic              ok,
  output logic              leaf,
  output logic [VA_W-1:0]   next_base,
  output logic [VA_W-1:0]   leaf_pa,
  output logic [VA_W-1:0]   leaf_mask,
  output logic              wr
);
  logic [VA_W-1:0] out_keep;

  always_comb begin
    ok        = desc_ok(desc, lvl);
    leaf      = desc_is_leaf(desc, lvl);
    next_base = {desc[VA_W-1:TBL_SH], {TBL_SH{1'b0}}};
    out_keep  = {VA_W{1'b1}} << out_shift(lvl);
    leaf_pa   = (desc[VA_W-1:0] & out_keep) | (va & ~out_keep);
    leaf_mask = {VA_W{1'b1}} << mask_shift(desc, lvl);
    wr        = may_write(desc, stage2);
  end
endmodule

// File: rtl/pt16_walker.sv
module pt16_walker import pt16_pkg::*; (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [VA_W-1:0]   req_va,
  input  logic [VA_W-1:0]   req_base,
  input  logic              req_stage2,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic [VA_W-1:0]   mem_addr,
  input  logic              mem_rsp_valid,
  input  logic [DESC_W-1:0] mem_rsp_data,
  output logic              done,
  output logic              fault,
  output logic [LVL_W-1:0]  end_level,
  output logic [VA_W-1:0]   out_pa,
  output logic [VA_W-1:0]   page_mask,
  output logic              writable
);
  localparam logic [VA_W-1:0] M_PG   = {VA_W{1'b1}} << PG_SH;
  localparam logic [VA_W-1:0] M_PGC  = {VA_W{1'b1}} << PG_CSH;
  localparam logic [VA_W-1:0] M_BLK  = {VA_W{1'b1}} << BLK_SH;
  localparam logic [VA_W-1:0] M_BLKC = {VA_W{1'b1}} << BLK_CSH;

  walk_st_e          state;
  logic [LVL_W-1:0]  lvl_q;
  logic [VA_W-1:0]   va_q;
  logic [VA_W-1:0]   tbl_q;
  logic              s2_q;
  logic [DESC_W-1:0] desc_q;

  logic              d_ok, d_leaf, d_wr;
  logic [VA_W-1:0]   d_next, d_pa, d_mask;

  // named internal events
  logic accept_req, rd_fire, rsp_take, walk_end, descend;

  assign req_ready     = (state == ST_IDLE);
  assign mem_req_valid = (state == ST_ISSUE);
  assign done          = (state == ST_DONE);
  assign accept_req    = req_valid & req_ready;
  assign rd_fire       = mem_req_valid & mem_req_ready;
  assign rsp_take      = (state == ST_WAIT) & mem_rsp_valid;
  assign walk_end      = (state == ST_DECODE) & (~d_ok | d_leaf);
  assign descend       = (state == ST_DECODE) & d_ok & ~d_leaf;

  pt16_addr u_addr (
    .table_base (tbl_q),
    .va         (va_q),
    .lvl        (lvl_q),
    .rd_addr    (mem_addr)
  );

  pt16_decode u_dec (
    .desc      (desc_q),
    .lvl       (lvl_q),
    .va        (va_q),
    .stage2    (s2_q),
    .ok        (d_ok),
    .leaf      (d_leaf),
    .next_base (d_next),
    .leaf_pa   (d_pa),
    .leaf_mask (d_mask),
    .wr        (d_wr)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      lvl_q  <= '0;
      va_q   <= '0;
      tbl_q  <= '0;
      s2_q   <= 1'b0;
      desc_q <= '0;
    end else begin
      case (state)
        ST_IDLE: if (accept_req) begin
          va_q  <= req_va;
          tbl_q <= req_base;
          s2_q  <= req_stage2;
          lvl_q <= '0;
          state <= ST_ISSUE;
        end
        ST_ISSUE: if (rd_fire) state <= ST_WAIT;
        ST_WAIT: if (rsp_take) begin
          desc_q <= mem_rsp_data;
          state  <= ST_DECODE;
        end
        ST_DECODE: begin
          if (descend) begin
            tbl_q <= d_next;
            lvl_q <= lvl_q + 2'd1;
            state <= ST_ISSUE;
          end else begin
            state <= ST_DONE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fault     <= 1'b0;
      end_level <= '0;
      out_pa    <= '0;
      page_mask <= '0;
      writable  <= 1'b0;
    end else if (walk_end) begin
      fault     <= ~d_ok;
      end_level <= lvl_q;
      out_pa    <= d_ok ? d_pa   : '0;
      page_mask <= d_ok ? d_mask : '0;
      writable  <= d_ok & d_wr;
    end
  end

  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R9
  AST_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    accept_req |=> (!req_ready && !done)); // R9
  AST_READ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_addr))); // R10
  AST_LEAF_DEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !fault) |-> (end_level >= 2'd2)); // R4
  AST_NO_DESCEND_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    descend |-> (lvl_q != LAST_LVL)); // R4
  AST_MASK_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !fault) |-> (page_mask == M_PG || page_mask == M_PGC ||
                          page_mask == M_BLK || page_mask == M_BLKC)); // R7
  AST_FAULT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (done && fault) |-> (!writable && page_mask == '0)); // R3
endmodule

// File: tb/pt16_walker_test.sv
module pt16_walker_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [47:0] req_va = '0;
  logic [47:0] req_base = '0;
  logic        req_stage2 = 1'b0;
  logic        mem_req_valid;
  logic        mem_req_ready = 1'b0;
  logic [47:0] mem_addr;
  logic        mem_rsp_valid = 1'b0;
  logic [63:0] mem_rsp_data = '0;
  logic        done, fault, writable;
  logic [1:0]  end_level;
  logic [47:0] out_pa, page_mask;

  always #2 clk = ~clk;

  pt16_walker uut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_va(req_va),
    .req_base(req_base), .req_stage2(req_stage2),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready), .mem_addr(mem_addr),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
    .done(done), .fault(fault), .end_level(end_level), .out_pa(out_pa),
    .page_mask(page_mask), .writable(writable)
  );

  int n_chk = 0, n_bad = 0;
  bit finished = 0;
  logic [63:0] mem [logic [47:0]];
  logic [47:0] addr_q [$];
  bit          exp_pend = 0;
  logic        e_fault, e_wr;
  logic [1:0]  e_lvl;
  logic [47:0] e_pa, e_mask;
  int          cyc = 0, ready_wait = 0, rsp_cnt = 0, walks_done = 0;
  bit          rsp_pend = 0, prev_done = 0, hold_v = 0;
  logic [47:0] rsp_addr, hold_a;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [63:0] rd_mem(input logic [47:0] a);
    if (mem.exists(a)) return mem[a];
    return 64'd0;
  endfunction

  function automatic logic [47:0] ref_idx(input logic [47:0] va, input int lv);
    int sh, w;
    if (lv == 0) begin sh = 47; w = 1; end
    else begin sh = 36 - 11 * (lv - 1); w = 11; end
    return (va >> sh) & ((48'd1 << w) - 48'd1);
  endfunction

  task automatic put(input int lv, input logic [47:0] va, input logic [47:0] tbl, input logic [63:0] d);
    mem[tbl + (ref_idx(va, lv) << 3)] = d;
  endtask

  task automatic ref_walk(input logic [47:0] va, input logic [47:0] base, input logic s2);
    logic [47:0] tb, a;
    logic [63:0] d;
    int n, cn;
    tb = base;
    for (int lv = 0; lv < 4; lv++) begin
      a = tb + (ref_idx(va, lv) << 3);
      addr_q.push_back(a);
      d = rd_mem(a);
      if (!(d[0] && (lv < 3 || d[1]))) begin
        e_fault = 1; e_lvl = 2'(lv); e_pa = '0; e_mask = '0; e_wr = 0;
        return;
      end
      if (lv == 3 || (lv == 2 && !d[1])) begin
        n  = (lv == 2) ? 25 : 14;
        cn = d[52] ? ((lv == 2) ? 30 : 21) : n;
        e_fault = 0; e_lvl = 2'(lv);
        e_pa   = ((d[47:0] >> n) << n) | (va & ((48'd1 << n) - 48'd1));
        e_mask = {48{1'b1}} << cn;
        e_wr   = s2 ? (d[7:6] == 2'b11) : !d[7];
        return;
      end
      tb = {d[47:12], 12'h000};
    end
  endtask

  // per-clock reference comparison and memory responder
  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      chk(!(done && prev_done), "R9 done single cycle", 64'(done), 64'd0);
      if (prev_done) chk(req_ready, "R9 ready after done", 64'(req_ready), 64'd1);
      chk(!mem_req_valid || addr_q.size() > 0, "R10 no unexpected read", 64'(mem_req_valid), 64'd0);
      if (hold_v) chk(mem_req_valid && mem_addr == hold_a, "R10 read held stable", 64'(mem_addr), 64'(hold_a));
      mem_rsp_valid = 1'b0;
      if (rsp_pend) begin
        if (rsp_cnt == 0) begin
          mem_rsp_valid = 1'b1;
          mem_rsp_data  = rd_mem(rsp_addr);
          rsp_pend = 0;
        end else rsp_cnt--;
      end
      hold_v = 0;
      if (mem_req_valid && !mem_req_ready && addr_q.size() > 0) begin
        if (ready_wait == 0) begin
          mem_req_ready = 1'b1;
          chk(mem_addr == addr_q[0], "R2 descriptor address", 64'(mem_addr), 64'(addr_q[0]));
          rsp_addr = addr_q.pop_front();
          rsp_pend = 1;
          rsp_cnt  = cyc % 3;
          ready_wait = cyc % 2;
        end else begin
          ready_wait--;
          mem_req_ready = 1'b0;
          hold_v = 1; hold_a = mem_addr;
        end
      end else mem_req_ready = 1'b0;
      if (done) begin
        chk(exp_pend, "R9 done expected", 64'(done), 64'(exp_pend));
        chk(addr_q.size() == 0, "R10 read count", 64'(addr_q.size()), 64'd0);
        chk(fault == e_fault, "R3 fault flag", 64'(fault), 64'(e_fault));
        chk(end_level == e_lvl, "R4 end level", 64'(end_level), 64'(e_lvl));
        chk(out_pa == e_pa, "R6 output address", 64'(out_pa), 64'(e_pa));
        chk(page_mask == e_mask, "R7 page mask", 64'(page_mask), 64'(e_mask));
        chk(writable == e_wr, "R8 writable", 64'(writable), 64'(e_wr));
        exp_pend = 0;
        walks_done++;
      end
      prev_done = done;
    end
  end

  task automatic walk(input logic [47:0] va, input logic [47:0] base, input logic s2, input bit poke);
    int target;
    while (!req_ready) @(negedge clk);
    ref_walk(va, base, s2);
    exp_pend = 1;
    target = walks_done + 1;
    req_va = va; req_base = base; req_stage2 = s2; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    if (poke) begin
      // R9: requests while busy must be ignored
      for (int i = 0; i < 2; i++) begin
        chk(!req_ready, "R9 busy not ready", 64'(req_ready), 64'd0);
        req_va = 48'h0050_0000_0000; req_base = 48'h0030_0000; req_valid = 1'b1;
        @(negedge clk);
      end
      req_valid = 1'b0;
    end
    while (walks_done < target) @(negedge clk);
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(negedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=hung expected=finished");
    summary();
  end

  initial begin
    logic [47:0] t0, t1, t2, t3, tb2;
    logic [47:0] va_a, va_b, va_c, va_d, va_e, va_f, va_g, va_h;
    t0 = 48'h10_0000; t1 = 48'h10_4000; t2 = 48'h10_8000; t3 = 48'h10_C000; tb2 = 48'h20_0000;
    va_a = (48'd1 << 25) | 48'h12_3456;
    va_b = (48'd2 << 25) | (48'd3 << 14) | 48'h1ABC;
    va_c = (48'd3 << 25) | 48'h155_5555;
    va_d = 48'h8000_0000_0000;
    va_e = 48'd5 << 36;
    va_f = (48'd4 << 25) | (48'd7 << 14);
    va_g = (48'd2 << 25) | (48'd9 << 14) | 48'h0ABC;
    va_h = 48'h8000_0000_0000 | (48'd1 << 25) | 48'h42;
    // R5: tables carry junk in bits outside 47:12
    put(0, va_a, t0, {16'h0010, t1[47:12], 12'hA53});
    put(1, va_a, t1, {16'h0000, t2[47:12], 12'hA53});
    put(2, va_a, t2, 64'h0000_0000_4755_0401);
    put(2, va_b, t2, {16'h0000, t3[47:12], 12'hA53});
    put(3, va_b, t3, 64'h0010_0000_7765_C0C3);
    put(2, va_c, t2, 64'h0010_0000_8A00_0041);
    put(2, va_f, t2, {16'h0000, t3[47:12], 12'hA53});
    put(3, va_f, t3, 64'h0000_0000_9000_0001);
    put(3, va_g, t3, 64'h0000_0000_5554_4083);
    put(0, va_h, tb2, {16'h0000, t1[47:12], 12'hA53});

    repeat (3) @(negedge clk);
    chk(req_ready == 1'b1, "R1 reset ready", 64'(req_ready), 64'd1);
    chk(done == 1'b0, "R1 reset done", 64'(done), 64'd0);
    chk(mem_req_valid == 1'b0, "R1 reset read", 64'(mem_req_valid), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready && !done && !mem_req_valid, "R1 after reset", 64'({req_ready, done, mem_req_valid}), 64'b100);

    walk(va_a, t0, 1'b0, 0);  // R4 R6 R8 level-2 block, stage 1 writable
    walk(va_b, t0, 1'b1, 0);  // R5 R7 level-3 page, contiguous, stage 2 writable
    walk(va_c, t0, 1'b1, 0);  // R7 R8 contiguous block, stage 2 read-only
    walk(va_d, t0, 1'b0, 0);  // R3 fault at level 0
    walk(va_e, t0, 1'b0, 0);  // R3 fault at level 1
    walk(va_f, t0, 1'b0, 0);  // R3 level-3 bit 1 clear
    walk(va_g, t0, 1'b0, 0);  // R8 stage 1 bit 7 set
    walk(va_h, tb2, 1'b0, 0); // R2 level-0 index from bit 47
    walk(va_a, t0, 1'b0, 1);  // R9 ignored request while busy
    walk(va_b, t0, 1'b0, 0);  // R8 same page under stage 1 rule
    repeat (3) @(negedge clk);
    chk(walks_done == 10, "R9 walk count", 64'(walks_done), 64'd10);
    summary();
  end
endmodule